// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a bank of 32-bit configuration registers on a simple word-addressed bus with separate read and write strobes. Most of the registers are write-protected. A lock flag guards them. Two dedicated key locations change the flag, and each acts only when the low 16 bits of the written data match its magic value. A status location reports the flag. One single-bit scratch register sits outside the protection and can always be written.

The protected space holds four decoded windows. It contains a few holes that ignore writes and one location that always reads as a constant. While the bank is unlocked, a write that sets bit 0 of the reset-control register at 0x200 raises a one-cycle reset-request pulse. The reset logic of the system consumes that pulse. Read data is registered and returned one cycle after the read strobe.

Top module: `keyreg_bank`

## Requirements
- R1: After reset the bank is locked and location 0xC reads 1. The registers take these reset values: 0x100, 0x104 and 0x108 hold 0x0001A008, 0x10C holds 0x0000003F, 0x24C holds 0x00000040, and every other protected word holds 0.
- R2: The lock key and the unlock key are compared against wdata_i[15:0] only, and the upper bits are ignored.
  - A write of 0x767B to 0x4 locks the bank.
  - A write of 0xDF0D to 0x8 unlocks it.
  - Any other value written to either location leaves the lock state unchanged.
- R3: Locations 0x4 and 0x8 always read 0. Writes to 0xC are ignored.
- R4: Location 0x0 stores wdata_i[0] only and reads it back in bit 0. It is writable whether the bank is locked or unlocked.
- R5: While the bank is locked, writes to the protected windows are discarded and leave the stored values unchanged.
- R6: While the bank is unlocked, a write to a protected word stores all 32 bits, and a later read returns them. The protected windows are 0x100–0x11C, 0x200–0x258, 0x600–0x620 and 0xB00–0xB2C.
- R7: Writes to 0x10C, 0x250, 0x604, 0xB20 and 0xB2C are dropped even while the bank is unlocked. Location 0x604 always reads 0.
- R8: Location 0x25C always reads 1. Unmapped and misaligned addresses read 0.
- R9: rst_req_o is high for exactly the one cycle after a write to 0x200 with wdata_i[0]=1 while the bank is unlocked. The stored value updates on the same edge. The pulse never occurs while the bank is locked.
- R10: rdata_o is valid one cycle after rd_en_i and holds its value when no read is issued. A read in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rst_req_o | output | 1 | One-cycle reset-request pulse |

## Verification
The main function is key-gated writing. Directed sequences cover several cases, and each one separates a gating fault from a decode fault:
- writes while locked, which must change nothing;
- near-miss keys that differ in one low bit, which must not unlock the bank;
- correct keys with noisy upper bits, which must still act;
- writes to holes while unlocked, which must still be dropped.

A long random mix interleaves key writes, scratch writes, protected writes and reads across all windows. Every read is compared against a bench model, which exposes lost or leaked writes at any lock state. The reset-request pulse is checked on every write, so a pulse that is missing, comes while locked, or comes from the wrong location is each caught. A same-cycle write-and-read pair checks the old-value ordering.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
  localparam int NUM_RANGES = 4;
  localparam int RANGE_BASE [NUM_RANGES] = '{'h100, 'h200, 'h600, 'hB00};
  localparam int RANGE_WORDS[NUM_RANGES] = '{8, 23, 9, 12};

  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

  localparam int OFF_SCRATCH = 'h000;
  localparam int OFF_LOCK    = 'h004;
  localparam int OFF_UNLOCK  = 'h008;
  localparam int OFF_STATUS  = 'h00C;
  localparam int OFF_RSTCTL  = 'h200;
  localparam int OFF_CONST1  = 'h25C;
  localparam int OFF_RDZERO  = 'h604;

  localparam int NUM_WR_HOLES = 5;
  localparam int WR_HOLE[NUM_WR_HOLES] = '{'h10C, 'h250, 'h604, 'hB20, 'hB2C};

  function automatic int total_regs();
    int n = 0;
    for (int r = 0; r < NUM_RANGES; r++) n += RANGE_WORDS[r];
    return n;
  endfunction

  localparam int NUM_REGS = total_regs();
  localparam int IDX_W    = $clog2(NUM_REGS);

  // byte offset of flat register index
  function automatic int idx_to_off(int idx);
    int first = 0;
    int off   = -1;
    for (int r = 0; r < NUM_RANGES; r++) begin
      if (idx >= first && idx < first + RANGE_WORDS[r]) off = RANGE_BASE[r] + 4 * (idx - first);
      first += RANGE_WORDS[r];
    end
    return off;
  endfunction

  function automatic logic [31:0] reg_reset(int idx);
    case (idx_to_off(idx))
      'h100, 'h104, 'h108: return 32'h0001_A008;
      'h10C:               return 32'h0000_003F;
      'h24C:               return 32'h0000_0040;
      default:             return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_ok_o,
  output logic              rd_zero_o
);
  int off;
  assign off = int'(addr_i);

  always_comb begin
    int first;
    hit_o = 1'b0;
    idx_o = '0;
    first = 0;
    for (int r = 0; r < NUM_RANGES; r++) begin
      if (addr_i[1:0] == 2'b00 && off >= RANGE_BASE[r] &&
          off <= RANGE_BASE[r] + 4 * (RANGE_WORDS[r] - 1)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(first + (off - RANGE_BASE[r]) / 4);
      end
      first += RANGE_WORDS[r];
    end
  end

  always_comb begin
    wr_ok_o = 1'b1;
    for (int h = 0; h < NUM_WR_HOLES; h++)
      if (off == WR_HOLE[h]) wr_ok_o = 1'b0;
  end

  assign rd_zero_o = (off == OFF_RDZERO);
endmodule

// File: rtl/keyreg_lock.sv
module keyreg_lock
  import keyreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       key_i,
  output logic              locked_o
);
  logic lock_hit, unlock_hit;
  assign lock_hit   = wr_en_i && addr_i == ADDR_W'(OFF_LOCK)   && key_i == LOCK_KEY;
  assign unlock_hit = wr_en_i && addr_i == ADDR_W'(OFF_UNLOCK) && key_i == UNLOCK_KEY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         locked_o <= 1'b1;
    else if (lock_hit)   locked_o <= 1'b1;
    else if (unlock_hit) locked_o <= 1'b0;
  end
endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
  import keyreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] q_arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= DATA_W'(reg_reset(g));
      else if (we_i && idx_i == IDX_W'(g)) q <= wdata_i;
    end
    assign q_arr[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == IDX_W'(i)) rdata_o = q_arr[i];
  end
endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  logic             hit, wr_ok, rd_zero, locked, scratch, store_we;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] store_rd;

  keyreg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx), .wr_ok_o(wr_ok), .rd_zero_o(rd_zero)
  );

  keyreg_lock #(.ADDR_W(ADDR_W)) i_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .key_i(wdata_i[15:0]), .locked_o(locked)
  );

  assign store_we = wr_en_i && hit && wr_ok && !locked;

  keyreg_store #(.DATA_W(DATA_W)) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(store_we), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(store_rd)
  );

  // unprotected scratch bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scratch <= 1'b0;
    else if (wr_en_i && addr_i == ADDR_W'(OFF_SCRATCH)) scratch <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_o <= 1'b0;
    else rst_req_o <= wr_en_i && !locked && addr_i == ADDR_W'(OFF_RSTCTL) && wdata_i[0];
  end

  // read samples pre-write state, so a same-cycle write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      if (addr_i == ADDR_W'(OFF_SCRATCH))     rdata_o <= DATA_W'(scratch);
      else if (addr_i == ADDR_W'(OFF_STATUS)) rdata_o <= DATA_W'(locked);
      else if (addr_i == ADDR_W'(OFF_CONST1)) rdata_o <= DATA_W'(1);
      else if (hit && !rd_zero)               rdata_o <= store_rd;
      else                                    rdata_o <= '0;
    end
  end
endmodule

// File: rtl/keyreg_bank_chk.sv
module keyreg_bank_chk
  import keyreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rst_req_o,
  input logic              locked
);
  logic soft_rst_wr;
  assign soft_rst_wr = wr_en_i && !locked && addr_i == ADDR_W'(OFF_RSTCTL) && wdata_i[0];

  // R2
  unlock_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(OFF_UNLOCK) && wdata_i[15:0] == UNLOCK_KEY |=> !locked);
  // R2
  lock_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(OFF_LOCK) && wdata_i[15:0] == LOCK_KEY |=> locked);
  // R2
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ((addr_i == ADDR_W'(OFF_LOCK) && wdata_i[15:0] != LOCK_KEY) ||
                (addr_i == ADDR_W'(OFF_UNLOCK) && wdata_i[15:0] != UNLOCK_KEY)) |=> $stable(locked));
  // R1
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(OFF_STATUS) |=> rdata_o == DATA_W'($past(locked)));
  // R3
  key_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == ADDR_W'(OFF_LOCK) || addr_i == ADDR_W'(OFF_UNLOCK)) |=> rdata_o == '0);
  // R8
  const_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(OFF_CONST1) |=> rdata_o == DATA_W'(1));
  // R7
  rdzero_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_W'(OFF_RDZERO) |=> rdata_o == '0);
  // R9
  soft_rst_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_wr |=> rst_req_o);
  // R9
  soft_rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(soft_rst_wr));
  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind keyreg_bank keyreg_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o),
  .locked(locked)
);

// File: tb/test_keyreg_bank.sv
module test_keyreg_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyreg_bank i_keyreg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  // bench model from the requirements
  logic [31:0] mem [1024];
  logic        m_lock, m_scl;

  function automatic bit is_prot(logic [11:0] a);
    if (a[1:0] != 0) return 0;
    return (a >= 'h100 && a <= 'h11C) || (a >= 'h200 && a <= 'h258) ||
           (a >= 'h600 && a <= 'h620) || (a >= 'hB00 && a <= 'hB2C);
  endfunction

  function automatic bit is_hole(logic [11:0] a);
    return a == 'h10C || a == 'h250 || a == 'h604 || a == 'hB20 || a == 'hB2C;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    mem['h100 >> 2] = 32'h0001A008; mem['h104 >> 2] = 32'h0001A008;
    mem['h108 >> 2] = 32'h0001A008; mem['h10C >> 2] = 32'h3F;
    mem['h24C >> 2] = 32'h40;
    m_lock = 1; m_scl = 0;
  endfunction

  function automatic logic [31:0] model_rd(logic [11:0] a);
    case (a)
      'h000: return {31'b0, m_scl};
      'h004, 'h008: return 0;
      'h00C: return {31'b0, m_lock};
      'h25C: return 1;
      'h604: return 0;
      default: return is_prot(a) ? mem[a >> 2] : 0;
    endcase
  endfunction

  function automatic void model_wr(logic [11:0] a, logic [31:0] d);
    if (a == 'h000) m_scl = d[0];
    else if (a == 'h004) begin if (d[15:0] == 16'h767B) m_lock = 1; end
    else if (a == 'h008) begin if (d[15:0] == 16'hDF0D) m_lock = 0; end
    else if (is_prot(a) && !is_hole(a) && !m_lock) mem[a >> 2] = d;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 0) return "R4";
    if (a == 4 || a == 8) return "R3";
    if (a == 'hC) return "R1";
    if (a == 'h25C) return "R8";
    if (is_hole(a)) return "R7";
    if (is_prot(a)) return m_lock ? "R5" : "R6";
    return "R8";
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic [11:0] a, logic [31:0] d);
    logic exp_req;
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    exp_req = !m_lock && a == 'h200 && d[0];
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    check(rst_req == exp_req, "R9 rst_req", {31'b0, rst_req}, {31'b0, exp_req});
    wr_en = 0;
  endtask

  task automatic do_rd(logic [11:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_en = 1; addr = a; exp = model_rd(a);
    @(negedge clk);
    check(rdata == exp, tag, rdata, exp);
    check(rst_req == 0, "R9 idle", {31'b0, rst_req}, 0);
    rd_en = 0;
  endtask

  task automatic do_rw(logic [11:0] a, logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    wr_en = 1; rd_en = 1; addr = a; wdata = d; exp = model_rd(a);
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    check(rdata == exp, "R10 same-cycle old value", rdata, exp);
    wr_en = 0; rd_en = 0;
  endtask

  function automatic logic [11:0] rand_addr();
    int r;
    case ($urandom_range(0, 9))
      0: return 12'($urandom_range(0, 3) * 4);
      1: return 'h200;
      2: return 'h25C;
      3: begin
        r = $urandom_range(0, 4);
        return r == 0 ? 'h10C : r == 1 ? 'h250 : r == 2 ? 'h604 : r == 3 ? 'hB20 : 'hB2C;
      end
      4: return 12'('h100 + 4 * $urandom_range(0, 7));
      5: return 12'('h200 + 4 * $urandom_range(0, 22));
      6: return 12'('h600 + 4 * $urandom_range(0, 8));
      7: return 12'('hB00 + 4 * $urandom_range(0, 11));
      8: return 12'($urandom);
      default: return $urandom_range(0, 1) ? 12'h4 : 12'h8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check(rdata == 0, "R1 reset rdata", rdata, 0);
    check(rst_req == 0, "R1 reset rst_req", {31'b0, rst_req}, 0);
    rst_ni = 1;

    // R1 reset values and lock state
    do_rd('hC, "R1 locked after reset");
    do_rd('h100, "R1 pll reset"); do_rd('h108, "R1 pll reset");
    do_rd('h10C, "R1 status reset"); do_rd('h24C, "R1 reason reset");
    do_rd('hB04, "R1 zero reset");
    // R5 locked writes dropped
    do_wr('h100, 32'h1234_5678); do_rd('h100, "R5 locked write");
    do_wr('h200, 32'h1); do_rd('h200, "R5 locked rstctl");
    // R4 scratch always writable
    do_wr('h0, 32'hFFFF_FFFF); do_rd('h0, "R4 scratch bit0 locked");
    do_wr('h0, 32'hFFFF_FFFE); do_rd('h0, "R4 scratch clear");
    // R2 near-miss and noisy keys
    do_wr('h8, 32'h0000_DF0C); do_rd('hC, "R2 wrong unlock key");
    do_wr('h4, 32'h0000_DF0D); do_rd('hC, "R2 unlock key at lock addr");
    do_wr('h8, 32'hABCD_DF0D); do_rd('hC, "R2 unlock with upper bits");
    do_rd('h4, "R3 lock reads zero"); do_rd('h8, "R3 unlock reads zero");
    do_wr('hC, 32'h1); do_rd('hC, "R3 status write ignored");
    // R6 unlocked writes
    do_wr('h100, 32'hDEAD_BEEF); do_rd('h100, "R6 pll write");
    do_wr('hB28, 32'hA5A5_5A5A); do_rd('hB28, "R6 window write");
    // R7 holes
    do_wr('h10C, 32'hFFFF_FFFF); do_rd('h10C, "R7 hole 10C");
    do_wr('h604, 32'hFFFF_FFFF); do_rd('h604, "R7 hole 604");
    do_wr('hB2C, 32'h1111_1111); do_rd('hB2C, "R7 hole B2C");
    // R8 constant and unmapped
    do_rd('h25C, "R8 const one"); do_rd('h300, "R8 unmapped");
    do_rd('h102, "R8 misaligned");
    // R9 soft reset pulse
    do_wr('h200, 32'h0000_0002); do_rd('h200, "R9 no pulse bit0 clear");
    do_wr('h200, 32'h8000_0003); do_rd('h200, "R9 stored with pulse");
    // R10 same-cycle ordering
    do_rw('h104, 32'h0BAD_F00D); do_rd('h104, "R10 new value after");
    // R2 relock, then R9 no pulse while locked
    do_wr('h4, 32'hFFFF_767B); do_rd('hC, "R2 relock");
    do_wr('h200, 32'h1);

    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = rand_addr();
      d = $urandom;
      if (a == 'h4 && $urandom_range(0, 3) == 0) d[15:0] = 16'h767B;
      if (a == 'h8 && $urandom_range(0, 1) == 0) d[15:0] = 16'hDF0D;
      case ($urandom_range(0, 4))
        0, 1: do_wr(a, d);
        2, 3: do_rd(a, tag_of(a));
        default: do_rw(a, d);
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule